// File: doc/BRIEF.md
# Two-Way Register Mailbox with Packed Status Word

This block connects a host processor to an embedded controller through two word-wide circular queues. The host pushes 32-bit words into the outbound queue by writing a window address. The controller takes them from the head of that queue. The controller fills a return queue that the host drains by reading a second window address.

Everything the host needs to manage the exchange sits in one status word: the queue depth, both pointers, a ready flag, a reset bit, a doorbell toward the controller, and an interrupt enable/status pair whose status bit is cleared by writing one. Software computes occupancy itself from the pointer fields. The controller publishes its own status word with the same field positions, and the host can read it at a fourth address. The host interrupt output is the status bit gated by the enable bit.

Host addresses: 0 = host status word, 1 = outbound window (write), 2 = return window (read), 3 = controller status word (read only).

Top module: `mailbox_csr`

## Requirements
- R1: Host status word layout: [31:24] outbound depth, [23:16] outbound write pointer, [15:8] outbound read pointer, bit 5 overflow, bit 4 reset, bit 3 host ready, bit 2 doorbell (always reads 0), bit 1 interrupt status, bit 0 interrupt enable, other bits 0. After reset only the depth field is nonzero, and a write to address 0 loads bits 0, 3 and 4 as written.
- R2: A host write to address 1 stores the word and advances the write pointer by one. `c_rdata` shows the oldest unread word (0 when the queue is empty), and `c_pop` advances the read pointer when the queue is not empty.
- R3: A write to address 1 while the outbound queue holds depth words changes neither the queue nor the pointers and sets overflow (bit 5). Overflow stays set until a status write with bit 5 at 1 clears it.
- R4: A host read of address 2 returns the oldest return-queue word and advances that queue's read pointer. On an empty queue it returns 0 and leaves the pointers unchanged. A `c_push` into a full return queue is dropped.
- R5: Interrupt status (bit 1) is cleared by a status write with bit 1 at 1. A 0 there leaves it unchanged.
- R6: Interrupt status is set one cycle after `c_ring` is high, or after the controller's effective ready bit changes. A set in the same cycle as a clear wins. `h_irq` equals status AND enable.
- R7: A status write with bit 2 at 1 makes `c_doorbell` high for exactly the following cycle.
- R8: From the cycle in which reset (bit 4) reads 1, all four pointers read 0 and both ready bits read 0. While reset is set, window writes, window reads, pushes and pops have no effect. Writing bit 4 as 0 releases it.
- R9: Controller status word, on `c_status` and at host address 3: [31:24] return depth, [23:16] return write pointer, [15:8] return read pointer, bit 3 controller ready (`c_ready` masked by reset), other bits 0. `c_hcsr` mirrors the host status word.
- R10: Pointers are 8 bits and wrap modulo 256. Write pointer minus read pointer, taken modulo 256, equals the number of queued words and never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effect at address 2) |
| h_addr | input | 2 | Host register address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for `h_addr` |
| h_irq | output | 1 | Host interrupt |
| c_hcsr | output | 32 | Host status word as seen by the controller |
| c_status | output | 32 | Controller status word |
| c_rdata | output | 32 | Oldest outbound word |
| c_pop | input | 1 | Controller consumes the outbound head |
| c_push | input | 1 | Controller enqueues `c_wdata` |
| c_wdata | input | 32 | Word for the return queue |
| c_ready | input | 1 | Controller ready level |
| c_ring | input | 1 | Controller doorbell toward the host |
| c_doorbell | output | 1 | One-cycle pulse for a host doorbell |

## Verification
The hardest situation to reach is pointer wrap. The pointers only pass 255 back to 0 after hundreds of balanced push/pop pairs, and the depth of 5 does not divide 256, so the slot index and the pointer wrap at different times. The stimulus runs a long loop that moves words through both queues every cycle. It also fills and overflows the outbound queue, and it raises reset in the same cycle as a controller push. A queue-based reference model is compared against every output on every cycle.

// File: rtl/mailbox_csr.sv
module mailbox_csr #(
  parameter int H2C_DEPTH = 5,
  parameter int C2H_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic [1:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        h_irq,
  output logic [31:0] c_hcsr,
  output logic [31:0] c_status,
  output logic [31:0] c_rdata,
  input  logic        c_pop,
  input  logic        c_push,
  input  logic [31:0] c_wdata,
  input  logic        c_ready,
  input  logic        c_ring,
  output logic        c_doorbell
);
  localparam int HIW = (H2C_DEPTH > 1) ? $clog2(H2C_DEPTH) : 1;
  localparam int CIW = (C2H_DEPTH > 1) ? $clog2(C2H_DEPTH) : 1;
  localparam logic [7:0] HD = 8'(H2C_DEPTH);
  localparam logic [7:0] CD = 8'(C2H_DEPTH);
  localparam logic [HIW-1:0] HLAST = HIW'(H2C_DEPTH - 1);
  localparam logic [CIW-1:0] CLAST = CIW'(C2H_DEPTH - 1);

  logic [31:0] h_mem [H2C_DEPTH];
  logic [31:0] c_mem [C2H_DEPTH];
  logic [7:0] hw_ptr, hr_ptr, cw_ptr, cr_ptr;
  logic [HIW-1:0] hw_ix, hr_ix;
  logic [CIW-1:0] cw_ix, cr_ix;
  logic ie, is_q, rdy, rst_q, ovf, crdy_prev;

  wire [7:0] h_cnt = hw_ptr - hr_ptr;
  wire [7:0] c_cnt = cw_ptr - cr_ptr;
  wire h_full = (h_cnt == HD);
  wire c_full = (c_cnt == CD);
  wire h_empty = (h_cnt == 8'd0);
  wire c_empty = (c_cnt == 8'd0);

  wire csr_wr   = h_wr && h_addr == 2'd0;
  wire win_wr   = h_wr && h_addr == 2'd1 && !rst_q;
  wire h_push   = win_wr && !h_full;
  wire h_drop   = win_wr && h_full;
  wire win_rd   = h_rd && h_addr == 2'd2 && !rst_q && !c_empty;
  wire cpop_ok  = c_pop && !h_empty && !rst_q;
  wire cpush_ok = c_push && !c_full && !rst_q;
  wire rst_next = csr_wr ? h_wdata[4] : rst_q;
  wire clear_q  = rst_q || rst_next;
  wire crdy     = c_ready && !rst_q;

  assign c_hcsr   = {HD, hw_ptr, hr_ptr, 2'b00, ovf, rst_q, rdy, 1'b0, is_q, ie};
  assign c_status = {CD, cw_ptr, cr_ptr, 4'b0000, crdy, 3'b000};
  assign c_rdata  = h_empty ? 32'd0 : h_mem[hr_ix];
  assign h_irq    = is_q && ie;

  always_comb begin
    case (h_addr)
      2'd0:    h_rdata = c_hcsr;
      2'd2:    h_rdata = c_empty ? 32'd0 : c_mem[cr_ix];
      2'd3:    h_rdata = c_status;
      default: h_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (h_push) h_mem[hw_ix] <= h_wdata;
    if (cpush_ok) c_mem[cw_ix] <= c_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_q) begin
      hw_ptr <= '0; hr_ptr <= '0; cw_ptr <= '0; cr_ptr <= '0;
      hw_ix  <= '0; hr_ix  <= '0; cw_ix  <= '0; cr_ix  <= '0;
    end else begin
      if (h_push) begin
        hw_ptr <= hw_ptr + 8'd1;
        hw_ix  <= (hw_ix == HLAST) ? '0 : hw_ix + 1'b1;
      end
      if (cpop_ok) begin
        hr_ptr <= hr_ptr + 8'd1;
        hr_ix  <= (hr_ix == HLAST) ? '0 : hr_ix + 1'b1;
      end
      if (cpush_ok) begin
        cw_ptr <= cw_ptr + 8'd1;
        cw_ix  <= (cw_ix == CLAST) ? '0 : cw_ix + 1'b1;
      end
      if (win_rd) begin
        cr_ptr <= cr_ptr + 8'd1;
        cr_ix  <= (cr_ix == CLAST) ? '0 : cr_ix + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie <= 1'b0; is_q <= 1'b0; rdy <= 1'b0; rst_q <= 1'b0;
      ovf <= 1'b0; crdy_prev <= 1'b0; c_doorbell <= 1'b0;
    end else begin
      if (csr_wr) ie <= h_wdata[0];
      if (c_ring || crdy != crdy_prev) is_q <= 1'b1;
      else if (csr_wr && h_wdata[1]) is_q <= 1'b0;
      if (h_drop) ovf <= 1'b1;
      else if (csr_wr && h_wdata[5]) ovf <= 1'b0;
      rdy        <= (csr_wr ? h_wdata[3] : rdy) && !rst_next;
      rst_q      <= rst_next;
      crdy_prev  <= crdy;
      c_doorbell <= csr_wr && h_wdata[2];
    end
  end

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt <= HD && c_cnt <= CD);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 2'd1 && h_full && !rst_q) |=> ($stable(hw_ptr) && ovf));
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == 2'd2 && c_empty && !rst_q) |=> $stable(cr_ptr));
  p_ring_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_ring |=> is_q);
  p_doorbell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_doorbell |-> $past(h_wr && h_addr == 2'd0 && h_wdata[2]));
  p_reset_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (hw_ptr == 8'd0 && cw_ptr == 8'd0 && hr_ptr == 8'd0 &&
               cr_ptr == 8'd0 && !rdy && !c_status[3]));
endmodule

// File: tb/test_mailbox_csr.sv
module test_mailbox_csr;
  localparam int PERIOD = 10;
  localparam int HD = 5;
  localparam int CD = 4;

  logic clk = 0, rst_n = 0;
  logic h_wr = 0, h_rd = 0, c_pop = 0, c_push = 0, c_ready = 0, c_ring = 0;
  logic [1:0] h_addr = 0;
  logic [31:0] h_wdata = 0, c_wdata = 0;
  logic [31:0] h_rdata, c_hcsr, c_status, c_rdata;
  logic h_irq, c_doorbell;

  mailbox_csr #(.H2C_DEPTH(HD), .C2H_DEPTH(CD)) i_mailbox_csr (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .c_hcsr(c_hcsr),
    .c_status(c_status), .c_rdata(c_rdata), .c_pop(c_pop), .c_push(c_push),
    .c_wdata(c_wdata), .c_ready(c_ready), .c_ring(c_ring), .c_doorbell(c_doorbell));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";
  logic [31:0] q_out[$], q_ret[$];
  int hwp, hrp, cwp, crp;
  logic m_ie, m_is, m_rdy, m_rst, m_ovf, m_prev, m_db;

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] ehcsr, ecst, ehr;
    ehcsr = {8'(HD), 8'(hwp), 8'(hrp), 2'b00, m_ovf, m_rst, m_rdy, 1'b0, m_is, m_ie};
    ecst  = {8'(CD), 8'(cwp), 8'(crp), 4'b0000, c_ready & ~m_rst, 3'b000};
    case (h_addr)
      2'd0: ehr = ehcsr;
      2'd2: ehr = (q_ret.size() > 0) ? q_ret[0] : 32'd0;
      2'd3: ehr = ecst;
      default: ehr = 32'd0;
    endcase
    chk({tag, " hcsr"}, c_hcsr, ehcsr);
    chk({tag, " cstatus"}, c_status, ecst);
    chk({tag, " h_rdata"}, h_rdata, ehr);
    chk({tag, " c_rdata"}, c_rdata, (q_out.size() > 0) ? q_out[0] : 32'd0);
    chk({tag, " irq"}, {31'd0, h_irq}, {31'd0, m_is & m_ie});
    chk({tag, " doorbell"}, {31'd0, c_doorbell}, {31'd0, m_db});
  endtask

  task automatic model_update();
    logic csr, rn, cr;
    csr = h_wr && h_addr == 2'd0;
    rn = csr ? h_wdata[4] : m_rst;
    cr = c_ready & ~m_rst;
    if (!m_rst) begin
      if (h_wr && h_addr == 2'd1) begin
        if (q_out.size() < HD) begin q_out.push_back(h_wdata); hwp = (hwp + 1) % 256; end
        else m_ovf = 1'b1;
      end
      if (c_pop && q_out.size() > 0) begin void'(q_out.pop_front()); hrp = (hrp + 1) % 256; end
      if (h_rd && h_addr == 2'd2 && q_ret.size() > 0) begin void'(q_ret.pop_front()); crp = (crp + 1) % 256; end
      if (c_push && q_ret.size() < CD) begin q_ret.push_back(c_wdata); cwp = (cwp + 1) % 256; end
    end
    if (m_rst || rn) begin q_out.delete(); q_ret.delete(); hwp = 0; hrp = 0; cwp = 0; crp = 0; end
    if (csr && h_wdata[5] && !(h_wr && h_addr == 2'd1 && !m_rst)) m_ovf = 1'b0;
    if (c_ring || cr != m_prev) m_is = 1'b1;
    else if (csr && h_wdata[1]) m_is = 1'b0;
    if (csr) m_ie = h_wdata[0];
    m_rdy = (csr ? h_wdata[3] : m_rdy) & ~rn;
    m_rst = rn;
    m_prev = cr;
    m_db = csr & h_wdata[2];
  endtask

  task automatic step(logic wr, logic rd, logic [1:0] a, logic [31:0] wd,
                      logic cpush, logic [31:0] cwd, logic cpop, logic ring);
    h_wr = wr; h_rd = rd; h_addr = a; h_wdata = wd;
    c_push = cpush; c_wdata = cwd; c_pop = cpop; c_ring = ring;
    #(PERIOD/4);
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic hwrite(logic [1:0] a, logic [31:0] wd);
    step(1, 0, a, wd, 0, 0, 0, 0);
  endtask

  task automatic idle(logic [1:0] a);
    step(0, 0, a, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hwp = 0; hrp = 0; cwp = 0; crp = 0;
    m_ie = 0; m_is = 0; m_rdy = 0; m_rst = 0; m_ovf = 0; m_prev = 0; m_db = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #(PERIOD/4);
    chk("R1 reset state", h_rdata, {8'(HD), 24'd0});
    @(negedge clk);

    tag = "R1"; hwrite(0, 32'h0000_0009); idle(0);
    hwrite(0, 32'hFFFF_FF40); idle(0);
    hwrite(0, 32'h0000_0009); idle(0);

    tag = "R2";
    for (int i = 0; i < 3; i++) hwrite(1, 32'hA000_0000 + i);
    step(0, 0, 0, 0, 0, 0, 1, 0); idle(0);
    step(0, 0, 0, 0, 0, 0, 1, 0); idle(0);

    tag = "R3";
    for (int i = 0; i < 6; i++) hwrite(1, 32'hB000_0000 + i);
    idle(0);
    hwrite(0, 32'h0000_0009); idle(0);
    hwrite(0, 32'h0000_0029); idle(0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 0);

    tag = "R4";
    step(0, 1, 2, 0, 0, 0, 0, 0); idle(3);
    step(0, 0, 3, 0, 1, 32'hC000_0001, 0, 0);
    step(0, 0, 3, 0, 1, 32'hC000_0002, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 2, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 3, 0, 1, 32'hC100_0000 + i, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 2, 0, 0, 0, 0, 0);

    tag = "R5";
    step(0, 0, 0, 0, 0, 0, 0, 1); idle(0);
    hwrite(0, 32'h0000_0009); idle(0);
    hwrite(0, 32'h0000_000B); idle(0);

    tag = "R6";
    c_ready = 1; idle(0); idle(0);
    hwrite(0, 32'h0000_0008); idle(0);
    hwrite(0, 32'h0000_0003); idle(0);
    step(1, 0, 0, 32'h0000_0003, 0, 0, 0, 1); idle(0);

    tag = "R7";
    hwrite(0, 32'h0000_000D); idle(0); idle(0);

    tag = "R9";
    step(0, 0, 3, 0, 1, 32'hD000_0001, 0, 0); idle(3);

    tag = "R8";
    hwrite(1, 32'hE000_0001);
    step(1, 0, 0, 32'h0000_001F, 1, 32'hE000_0002, 0, 0);
    idle(0); idle(3);
    hwrite(1, 32'hE000_0003);
    step(0, 1, 2, 0, 1, 32'hE000_0004, 1, 0);
    idle(0);
    hwrite(0, 32'h0000_000D); idle(0); idle(3);

    tag = "R10";
    for (int i = 0; i < 300; i++) begin
      hwrite(1, 32'h1000_0000 + i);
      step(0, 0, 0, 0, 1, 32'h2000_0000 + i, 1, 0);
      step(0, 1, 2, 0, 0, 0, 0, 0);
    end
    idle(0); idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule